// File: doc/BRIEF.md
# Overload Shutdown Timer with Up/Down Cycle Count

This block decides when a switching converter has been overloaded for long enough to stop switching. A feedback comparator supplies a one-bit overload flag, and the oscillator supplies a strobe once per switching cycle. On every strobe, an up/down counter steps up when the flag is set and steps down when it is clear. The counter is never simply reset when the flag clears. Short overloads that repeat before the count has drained therefore add up. Slower switching also makes the drain take longer.

When the count reaches the configured delay, the gate-enable output drops. A parameter chooses what happens next:

- **Auto-restart variant:** the block counts a fixed number of pulses on a slow tick input. Switching pulses are absent during this wait, so the tick is the timebase. After the last tick, the block enables the gate again with the count at zero.
- **Latch variant:** the block raises a latch request and keeps the gate off until a supply lockout.

The lockout input clears every piece of state and holds the gate off while it is high. A synchronous active-high reset returns the block to its running state.

Top module: `olp_updown_timer`

## Requirements
- R1: After reset, gate_en is 1 and latch_req is 0.
- R2: Each clock with sw_strobe=1 and ovl_flag=1 raises the count by one. A clock without sw_strobe leaves the count unchanged. gate_en falls after the edge that samples the DELAY_CYC-th net overloaded strobe.
- R3: Each clock with sw_strobe=1 and ovl_flag=0 lowers the count by one. The count saturates at zero and never wraps.
- R4: If overload strobes stop before the count reaches DELAY_CYC, gate_en stays 1 without interruption.
- R5: Counts from separate overload bursts accumulate. After k up-steps and j down-steps (k>j), exactly DELAY_CYC-(k-j) further overload strobes trip the block.
- R6: In the auto-restart variant (LATCH_MODE=0), gate_en stays 0 after a trip until RESTART_TICKS pulses of wait_tick have been sampled. It returns to 1 after the edge that samples the last of them.
- R7: After an automatic restart the count is zero, so a full DELAY_CYC overload strobes are needed to trip again.
- R8: In the latch variant (LATCH_MODE=1), latch_req becomes 1 after the edge that trips the block. gate_en then stays 0 and latch_req stays 1, whatever the other inputs do, until lockout.
- R9: While lockout=1, gate_en is 0 in the same cycle. The edge that samples lockout clears the count, the wait timer and latch_req.
- R10: wait_tick has no effect while switching runs. sw_strobe and ovl_flag have no effect while switching is stopped.
- R11: gate_en and latch_req are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lockout | input | 1 | Supply lockout; clears all state and forces the gate off |
| sw_strobe | input | 1 | One-cycle pulse per switching cycle |
| ovl_flag | input | 1 | Overload comparator output |
| wait_tick | input | 1 | Slow timebase pulse for the restart wait |
| gate_en | output | 1 | Switching permitted |
| latch_req | output | 1 | Permanent shutdown request (latch variant) |

## Verification
The bench drains the count past zero and then needs exactly DELAY_CYC overload strobes to trip. A counter that wraps would never trip, or would trip late. It builds the count with a burst, partly drains it, and then trips early. A design that resets on clear would need the full delay here.

The bench sends overload strobes during the restart wait and ticks during normal running. A design that listens at the wrong time would restart early or keep a stale wait count. The bench asserts lockout in the middle of the wait and while latched. After release, it needs a full delay to trip again, which exposes any count or latch request that lockout failed to clear. A behavioural model of both variants checks the outputs on every clock, including under random stimulus.

// File: rtl/olp_pkg.sv
package olp_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_WAIT  = 2'd1,
        ST_LATCH = 2'd2
    } olp_state_e;

    typedef struct packed {
        logic clear;
        logic up;
        logic down;
    } cnt_cmd_t;

    // bits needed to hold values 0..n
    function automatic int unsigned bits_for(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/olp_updown_cnt.sv
module olp_updown_cnt
    import olp_pkg::*;
#(
    parameter int unsigned LIMIT = 12000,
    localparam int unsigned W    = bits_for(LIMIT)
) (
    input  logic     clk,
    input  cnt_cmd_t cmd,
    output logic     near_limit
);
    localparam logic [W-1:0] TOP  = W'(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] count;

    always_ff @(posedge clk) begin
        if (cmd.clear) begin
            count <= '0;
        end else if (cmd.up) begin
            if (count != TOP) count <= count + W'(1);
        end else if (cmd.down) begin
            if (count != '0) count <= count - W'(1);
        end
    end

    assign near_limit = (count == LAST);
endmodule

// File: rtl/olp_restart_wait.sv
module olp_restart_wait
    import olp_pkg::*;
#(
    parameter int unsigned TICKS = 7,
    localparam int unsigned W    = bits_for(TICKS)
) (
    input  logic clk,
    input  logic clear,
    input  logic advance,
    output logic done
);
    localparam logic [W-1:0] LAST = W'(TICKS - 1);

    logic [W-1:0] ticks_seen;

    assign done = advance && (ticks_seen == LAST);

    always_ff @(posedge clk) begin
        if (clear || done) begin
            ticks_seen <= '0;
        end else if (advance) begin
            ticks_seen <= ticks_seen + W'(1);
        end
    end
endmodule

// File: rtl/olp_mode_fsm.sv
module olp_mode_fsm
    import olp_pkg::*;
#(
    parameter bit LATCH_MODE = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       lockout,
    input  logic       sw_strobe,
    input  logic       ovl_flag,
    input  logic       wait_tick,
    input  logic       near_limit,
    input  logic       wait_done,
    output olp_state_e state,
    output cnt_cmd_t   cnt_cmd,
    output logic       wait_adv,
    output logic       wait_clr
);
    olp_state_e stop_dest;
    olp_state_e state_nx;
    logic       kill;
    logic       running;
    logic       trip;

    generate
        if (LATCH_MODE) begin : g_latch
            assign stop_dest = ST_LATCH;
        end else begin : g_auto
            assign stop_dest = ST_WAIT;
        end
    endgenerate

    assign kill    = rst || lockout;
    assign running = (state == ST_RUN);
    assign trip    = running && sw_strobe && ovl_flag && near_limit;

    always_comb begin
        cnt_cmd.clear = kill || ((state == ST_WAIT) && wait_done);
        cnt_cmd.up    = running && sw_strobe && ovl_flag;
        cnt_cmd.down  = running && sw_strobe && !ovl_flag;
    end

    assign wait_adv = (state == ST_WAIT) && wait_tick;
    assign wait_clr = kill;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (trip) state_nx = stop_dest;
            ST_WAIT:  if (wait_done) state_nx = ST_RUN;
            ST_LATCH: state_nx = ST_LATCH;
            default:  state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (kill) state <= ST_RUN;
        else      state <= state_nx;
    end
endmodule

// File: rtl/olp_updown_timer.sv
module olp_updown_timer
    import olp_pkg::*;
#(
    parameter int unsigned DELAY_CYC     = 12000,
    parameter int unsigned RESTART_TICKS = 7,
    parameter bit          LATCH_MODE    = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lockout,
    input  logic sw_strobe,
    input  logic ovl_flag,
    input  logic wait_tick,
    output logic gate_en,
    output logic latch_req
);
    olp_state_e state;
    cnt_cmd_t   cnt_cmd;
    logic       near_limit;
    logic       wait_adv;
    logic       wait_clr;
    logic       wait_done;

    olp_mode_fsm #(.LATCH_MODE(LATCH_MODE)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .lockout    (lockout),
        .sw_strobe  (sw_strobe),
        .ovl_flag   (ovl_flag),
        .wait_tick  (wait_tick),
        .near_limit (near_limit),
        .wait_done  (wait_done),
        .state      (state),
        .cnt_cmd    (cnt_cmd),
        .wait_adv   (wait_adv),
        .wait_clr   (wait_clr)
    );

    olp_updown_cnt #(.LIMIT(DELAY_CYC)) u_cnt (
        .clk        (clk),
        .cmd        (cnt_cmd),
        .near_limit (near_limit)
    );

    olp_restart_wait #(.TICKS(RESTART_TICKS)) u_wait (
        .clk     (clk),
        .clear   (wait_clr),
        .advance (wait_adv),
        .done    (wait_done)
    );

    assign gate_en   = (state == ST_RUN) && !lockout;
    assign latch_req = (state == ST_LATCH);
endmodule

// File: rtl/olp_updown_timer_chk.sv
module olp_updown_timer_chk #(
    parameter bit LATCH_MODE = 1'b0
) (
    input logic clk,
    input logic rst,
    input logic lockout,
    input logic sw_strobe,
    input logic ovl_flag,
    input logic wait_tick,
    input logic gate_en,
    input logic latch_req
);
    assert_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(gate_en && latch_req));

    assert_lockout_gate_R9: assert property (@(posedge clk) disable iff (rst)
        lockout |-> !gate_en);

    assert_lockout_clears_R9: assert property (@(posedge clk) disable iff (rst)
        lockout |=> !latch_req);

    assert_drop_needs_overload_R2: assert property (@(posedge clk) disable iff (rst)
        gate_en && !(sw_strobe && ovl_flag) |=> gate_en || lockout);

    generate
        if (LATCH_MODE) begin : g_latch_chk
            assert_latch_sticky_R8: assert property (@(posedge clk) disable iff (rst)
                latch_req && !lockout |=> latch_req);
            assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
                !gate_en && !lockout |=> !gate_en);
        end else begin : g_auto_chk
            assert_wait_needs_tick_R6: assert property (@(posedge clk) disable iff (rst)
                !gate_en && !lockout && !wait_tick |=> !gate_en);
            assert_no_latch_R8: assert property (@(posedge clk) disable iff (rst)
                !latch_req);
        end
    endgenerate
endmodule

bind olp_updown_timer olp_updown_timer_chk #(.LATCH_MODE(LATCH_MODE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lockout   (lockout),
    .sw_strobe (sw_strobe),
    .ovl_flag  (ovl_flag),
    .wait_tick (wait_tick),
    .gate_en   (gate_en),
    .latch_req (latch_req)
);

// File: tb/olp_updown_timer_tb.sv
module olp_updown_timer_tb;
    localparam int DLY = 10;
    localparam int WT  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lockout = 1'b0;
    logic sw_strobe = 1'b0;
    logic ovl_flag = 1'b0;
    logic wait_tick = 1'b0;
    logic gate_a, latch_a, gate_l, latch_l;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    olp_updown_timer #(.DELAY_CYC(DLY), .RESTART_TICKS(WT), .LATCH_MODE(1'b0)) u_dut (
        .clk(clk), .rst(rst), .lockout(lockout), .sw_strobe(sw_strobe),
        .ovl_flag(ovl_flag), .wait_tick(wait_tick), .gate_en(gate_a), .latch_req(latch_a));

    olp_updown_timer #(.DELAY_CYC(DLY), .RESTART_TICKS(WT), .LATCH_MODE(1'b1)) u_dut_latch (
        .clk(clk), .rst(rst), .lockout(lockout), .sw_strobe(sw_strobe),
        .ovl_flag(ovl_flag), .wait_tick(wait_tick), .gate_en(gate_l), .latch_req(latch_l));

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // behavioural reference: 0 = running, 1 = waiting, 2 = latched
    int m_st[2];
    int m_cnt[2];
    int m_w[2];

    always @(posedge clk) begin
        for (int v = 0; v < 2; v++) begin
            if (rst || lockout) begin
                m_st[v] = 0; m_cnt[v] = 0; m_w[v] = 0;
            end else if (m_st[v] == 0) begin
                if (sw_strobe) begin
                    if (ovl_flag) begin
                        m_cnt[v] = m_cnt[v] + 1;
                        if (m_cnt[v] == DLY) m_st[v] = (v == 1) ? 2 : 1;
                    end else if (m_cnt[v] > 0) begin
                        m_cnt[v] = m_cnt[v] - 1;
                    end
                end
            end else if (m_st[v] == 1) begin
                if (wait_tick) begin
                    m_w[v] = m_w[v] + 1;
                    if (m_w[v] == WT) begin
                        m_st[v] = 0; m_cnt[v] = 0; m_w[v] = 0;
                    end
                end
            end
        end
        #4;
        if (!rst) begin
            chk("R2 model gate auto", gate_a, (m_st[0] == 0) && !lockout);
            chk("R6 model latch_req auto", latch_a, 1'b0);
            chk("R2 model gate latch", gate_l, (m_st[1] == 0) && !lockout);
            chk("R8 model latch_req latch", latch_l, m_st[1] == 2);
        end
    end

    // set inputs for one edge, return 2 ns after it
    task automatic cyc(input logic s, input logic o, input logic t, input logic l);
        sw_strobe = s; ovl_flag = o; wait_tick = t; lockout = l;
        @(posedge clk); #2;
    endtask

    task automatic strobes(input int n, input logic o);
        for (int i = 0; i < n; i++) cyc(1'b1, o, 1'b0, 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R1 gate after reset", gate_a, 1'b1);
        chk("R1 latch_req after reset", latch_l, 1'b0);

        // R4: stop one short of the limit
        strobes(DLY - 1, 1'b1);
        chk("R4 gate before limit", gate_a, 1'b1);
        strobes(DLY - 1, 1'b0);
        chk("R4 gate after clear", gate_a, 1'b1);
        // R2: no strobe, no count
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 1'b0, 1'b0);
        // R3: drain below zero must saturate
        strobes(5, 1'b0);
        strobes(DLY - 1, 1'b1);
        chk("R3 gate one short after saturate", gate_a, 1'b1);
        strobes(1, 1'b1);
        chk("R2 gate drops at limit auto", gate_a, 1'b0);
        chk("R2 gate drops at limit latch", gate_l, 1'b0);
        chk("R8 latch_req after trip", latch_l, 1'b1);

        // R6/R10: wait with strobes and ticks interleaved
        for (int i = 0; i < WT - 1; i++) begin
            cyc(1'b1, 1'b1, 1'b1, 1'b0);
            cyc(1'b1, 1'b0, 1'b0, 1'b0);
        end
        chk("R6 gate still off before last tick", gate_a, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R6 gate back after last tick", gate_a, 1'b1);
        chk("R8 latch variant stays off", gate_l, 1'b0);
        chk("R8 latch_req holds", latch_l, 1'b1);

        // R7: full delay needed again
        strobes(DLY - 1, 1'b1);
        chk("R7 no trip before full delay", gate_a, 1'b1);
        strobes(1, 1'b1);
        chk("R7 trip after full delay", gate_a, 1'b0);

        // R9: lockout
        sw_strobe = 0; ovl_flag = 0; wait_tick = 0; lockout = 1'b1;
        #1;
        chk("R9 gate low during lockout", gate_a, 1'b0);
        @(posedge clk); #2;
        chk("R9 latch_req cleared", latch_l, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 gate auto after release", gate_a, 1'b1);
        chk("R9 gate latch after release", gate_l, 1'b1);

        // R10: ticks while running do nothing
        for (int i = 0; i < 2 * WT; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10 ticks ignored while running", gate_a, 1'b1);

        // R5: accumulation
        strobes(6, 1'b1);
        strobes(2, 1'b0);
        strobes(DLY - 4 - 1, 1'b1);
        chk("R5 one short after accumulation", gate_l, 1'b1);
        strobes(1, 1'b1);
        chk("R5 early trip auto", gate_a, 1'b0);
        chk("R5 early trip latch", latch_l, 1'b1);

        // R9: lockout mid-wait clears wait and count
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b1);
        cyc(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 running after mid-wait lockout", gate_a, 1'b1);
        strobes(DLY - 1, 1'b1);
        chk("R9 count cleared by lockout", gate_a, 1'b1);
        strobes(1, 1'b1);
        chk("R9 trip after full delay", gate_a, 1'b0);
        chk("R11 not both high", gate_l & latch_l, 1'b0);

        // random traffic checked against the model
        for (int i = 0; i < 4000; i++) begin
            cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 9) < 6),
                1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 299) == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule